// File: doc/BRIEF.md
# Interrupt Signaling Mode Controller

This endpoint-side unit turns a set of level-sensitive internal interrupt sources into outgoing interrupt signaling. It runs in one of three modes. With both message enables off, it drives a legacy level output on one of four pins and issues a matching pair of virtual-wire messages: one when the combined level rises and one when it falls. With the single-address message mode on, each rising source edge produces a memory write to one programmed address. The vector number is merged into the low bits of the programmed data value. With the table-based message mode on, each vector's write takes its own address and data pair from a per-vector table entry, and each entry carries a mask bit.

Every vector keeps a pending bit. Each rising edge of its source raises the bit, and one message is issued per bit. The lowest-numbered eligible vector goes first. Outgoing requests leave through a single valid/ready channel that carries a kind code, an address and a data word. Whenever a message mode is on, legacy signaling is suppressed. If the legacy level was still asserted when a message mode came on, a release message is sent before any memory write.

Top module: `irq_signal_ctrl`

## Requirements
- R1: After reset, `msg_valid` is 0, `intx_out` is 0 and no vector is pending.
- R2: With `msi_on` and `msix_on` both 0, `intx_out` has only bit `leg_pin` set (pin code 0..3 = first..fourth pin) while any `irq_src` bit is 1. It is 0 otherwise. The output follows the sources one clock later.
- R3: In legacy mode, a rise of the combined source level issues a message of kind 1 (assert), and a fall issues kind 2 (release). Both carry `leg_pin` in `msg_data[1:0]` and address 0. Further source changes that leave the combined level unchanged issue nothing.
- R4: While `msi_on` or `msix_on` is 1, `intx_out` is 0 and no kind-1 message is issued.
- R5: If the legacy level was asserted when a message mode is enabled, a kind-2 message is issued before any memory write.
- R6: In single-address mode (`msi_on`=1, `msix_on`=0), a vector's message is kind 3 with address `msi_addr`. Its data is `msi_data` with the low `msi_log2` bits replaced by the same bits of the vector number. This aliases vectors onto the granted count of 2^`msi_log2`.
- R7: When `msix_on` is 1 (whether or not `msi_on` is also 1), a vector's message is kind 3 with the address and data last written to that vector's table entry through `tbl_we`/`tbl_idx`.
- R8: Each rising edge of a source in a message mode produces exactly one message. A source held high produces no further messages.
- R9: When several vectors are pending, the lowest-numbered eligible one is issued first.
- R10: In table mode, a vector whose entry mask bit is 1 stays pending and is not sent. It is sent once its entry is rewritten with the mask bit 0. Every mask bit is 1 after reset.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, `msg_kind`, `msg_addr` and `msg_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_VEC | Level interrupt sources, one per vector |
| msi_on | input | 1 | Single-address message mode enable |
| msix_on | input | 1 | Table message mode enable (wins over msi_on) |
| leg_pin | input | 2 | Legacy pin code, 0..3 |
| msi_addr | input | ADDR_W | Single-address mode target address |
| msi_data | input | 32 | Single-address mode base data |
| msi_log2 | input | LOG2_W | log2 of granted vector count |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_addr | input | ADDR_W | Table entry address |
| tbl_data | input | 32 | Table entry data |
| tbl_mask | input | 1 | Table entry mask bit |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_kind | output | 2 | 0 idle, 1 assert, 2 release, 3 memory write |
| msg_addr | output | ADDR_W | Message address |
| msg_data | output | 32 | Message data |
| intx_out | output | 4 | Legacy level output, one bit per pin |

## Verification
The hardest case to reach is a mode switch while the legacy level is still asserted. The release message must then come ahead of any memory write, and no stray vector message may be triggered. The bench brings the unit there by raising a source in legacy mode, taking the assert message, and then enabling a message mode with the source still high. Because the source is held, it produces no rising edge, so only the release may appear. A second hard case is a masked table entry sitting pending while an unmasked vector is served. The bench gets there by writing the masks first and only then raising both sources.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int IRQ_DATA_W = 32;

  typedef enum logic [1:0] {
    MK_IDLE    = 2'd0,
    MK_ASSERT  = 2'd1,
    MK_RELEASE = 2'd2,
    MK_MEMWR   = 2'd3
  } msg_kind_e;

  // Replace the low lg bits of base with the low lg bits of vec.
  function automatic logic [IRQ_DATA_W-1:0] msi_merge(
    input logic [IRQ_DATA_W-1:0] base,
    input logic [IRQ_DATA_W-1:0] vec,
    input int                    lg
  );
    logic [IRQ_DATA_W-1:0] m;
    for (int i = 0; i < IRQ_DATA_W; i++) m[i] = (i < lg);
    return (base & ~m) | (vec & m);
  endfunction
endpackage

// File: rtl/irq_edge_pending.sv
module irq_edge_pending #(
  parameter int NUM_VEC = 4,
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] src,
  input  logic               arm,
  input  logic [NUM_VEC-1:0] elig,
  input  logic               take,
  output logic               sel_any,
  output logic [IDX_W-1:0]   sel_idx
);
  logic [NUM_VEC-1:0] src_q, pend_q, rise, cand, sel_oh;

  assign rise = src & ~src_q;
  assign cand = pend_q & elig;

  always_comb begin
    sel_oh  = '0;
    sel_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel_oh  = '0;
        sel_oh[i] = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end
  assign sel_any = |cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q <= src;
      if (!arm) pend_q <= '0;
      else      pend_q <= (pend_q & ~(take ? sel_oh : '0)) | rise;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh)); // R9
  AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> ((pend_q & ~$past(pend_q) & ~$past(src)) == '0)); // R8
endmodule

// File: rtl/irq_msix_table.sv
module irq_msix_table #(
  parameter int NUM_VEC = 4,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32,
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               wmask,
  input  logic [IDX_W-1:0]   ridx,
  output logic [ADDR_W-1:0]  raddr,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_VEC-1:0] masks
);
  logic [ADDR_W-1:0] ent_addr [NUM_VEC];
  logic [DATA_W-1:0] ent_data [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_addr[g] <= '0;
        ent_data[g] <= '0;
        masks[g]    <= 1'b1;
      end else if (we && widx == IDX_W'(g)) begin
        ent_addr[g] <= waddr;
        ent_data[g] <= wdata;
        masks[g]    <= wmask;
      end
    end
  end

  assign raddr = ent_addr[ridx];
  assign rdata = ent_data[ridx];
endmodule

// File: rtl/irq_legacy_track.sv
module irq_legacy_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_src,
  input  logic       msg_mode,
  input  logic [1:0] pin,
  input  logic       take,
  output logic       want,
  output logic       want_assert,
  output logic [3:0] intx_out
);
  logic lvl_q, vw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      vw_q  <= 1'b0;
    end else begin
      lvl_q <= any_src & ~msg_mode;
      if (take) vw_q <= lvl_q;
    end
  end

  assign want        = lvl_q ^ vw_q;
  assign want_assert = lvl_q;
  assign intx_out    = lvl_q ? (4'b0001 << pin) : 4'b0000;

  AST_NO_LEGACY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode && $past(msg_mode) |-> intx_out == 4'b0000); // R4
  AST_PIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(intx_out)); // R2
endmodule

// File: rtl/irq_signal_ctrl.sv
module irq_signal_ctrl
  import irqs_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int ADDR_W  = 64,
  parameter int LOG2_W  = 3,
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int DW    = IRQ_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_src,
  input  logic               msi_on,
  input  logic               msix_on,
  input  logic [1:0]         leg_pin,
  input  logic [ADDR_W-1:0]  msi_addr,
  input  logic [DW-1:0]      msi_data,
  input  logic [LOG2_W-1:0]  msi_log2,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [ADDR_W-1:0]  tbl_addr,
  input  logic [DW-1:0]      tbl_data,
  input  logic               tbl_mask,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [1:0]         msg_kind,
  output logic [ADDR_W-1:0]  msg_addr,
  output logic [DW-1:0]      msg_data,
  output logic [3:0]         intx_out
);
  logic               msg_mode, load, take_leg, take_vec;
  logic               leg_want, leg_assert, vec_any;
  logic [IDX_W-1:0]   vec_idx;
  logic [NUM_VEC-1:0] tbl_masks, elig;
  logic [ADDR_W-1:0]  ent_addr;
  logic [DW-1:0]      ent_data;

  assign msg_mode = msi_on | msix_on;
  assign elig     = msix_on ? ~tbl_masks : '1;
  assign load     = ~msg_valid;
  assign take_leg = load & leg_want;
  assign take_vec = load & ~leg_want & vec_any;

  irq_legacy_track u_leg (
    .clk(clk), .rst_n(rst_n), .any_src(|irq_src), .msg_mode(msg_mode),
    .pin(leg_pin), .take(take_leg), .want(leg_want),
    .want_assert(leg_assert), .intx_out(intx_out)
  );

  irq_edge_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .arm(msg_mode), .elig(elig),
    .take(take_vec), .sel_any(vec_any), .sel_idx(vec_idx)
  );

  irq_msix_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .waddr(tbl_addr),
    .wdata(tbl_data), .wmask(tbl_mask), .ridx(vec_idx), .raddr(ent_addr),
    .rdata(ent_data), .masks(tbl_masks)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_kind  <= MK_IDLE;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take_leg) begin
      msg_valid <= 1'b1;
      msg_kind  <= leg_assert ? MK_ASSERT : MK_RELEASE;
      msg_addr  <= '0;
      msg_data  <= DW'(leg_pin);
    end else if (take_vec) begin
      msg_valid <= 1'b1;
      msg_kind  <= MK_MEMWR;
      msg_addr  <= msix_on ? ent_addr : msi_addr;
      msg_data  <= msix_on ? ent_data
                           : msi_merge(msi_data, DW'(vec_idx), int'(msi_log2));
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
      msg_kind  <= MK_IDLE;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind)
      && $stable(msg_addr) && $stable(msg_data)); // R11
  AST_NO_ASSERT_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && msg_kind == MK_ASSERT |-> !$past(msg_mode)); // R4
  AST_IDLE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> msg_kind == MK_IDLE); // R1
endmodule

// File: tb/irq_signal_ctrl_test.sv
module irq_signal_ctrl_test;
  localparam int NV = 4;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] irq_src = '0;
  logic          msi_on = 1'b0, msix_on = 1'b0;
  logic [1:0]    leg_pin = 2'd0;
  logic [AW-1:0] msi_addr = '0;
  logic [31:0]   msi_data = '0;
  logic [2:0]    msi_log2 = '0;
  logic          tbl_we = 1'b0;
  logic [1:0]    tbl_idx = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [31:0]   tbl_data = '0;
  logic          tbl_mask = 1'b0;
  logic          msg_valid, msg_ready = 1'b0;
  logic [1:0]    msg_kind;
  logic [AW-1:0] msg_addr;
  logic [31:0]   msg_data;
  logic [3:0]    intx_out;

  int checks = 0, errors = 0;
  logic [1:0]  c_kind;
  logic [AW-1:0] c_addr;
  logic [31:0] c_data;

  always #10 clk = ~clk;

  irq_signal_ctrl #(.NUM_VEC(NV), .ADDR_W(AW), .LOG2_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .msi_on(msi_on),
    .msix_on(msix_on), .leg_pin(leg_pin), .msi_addr(msi_addr),
    .msi_data(msi_data), .msi_log2(msi_log2), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .tbl_mask(tbl_mask), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_data(msg_data),
    .intx_out(intx_out)
  );

  // single-address merge vectors: log2, vector, base, expected data
  localparam logic [2:0]  T_LG  [5] = '{3'd0, 3'd2, 3'd1, 3'd2, 3'd3};
  localparam int          T_VEC [5] = '{3, 3, 3, 1, 2};
  localparam logic [31:0] T_BASE[5] = '{32'h4A30, 32'h4A30, 32'h4A30, 32'h4A30, 32'h4A3F};
  localparam logic [31:0] T_EXP [5] = '{32'h4A30, 32'h4A33, 32'h4A31, 32'h4A31, 32'h4A3A};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic get_msg();
    int n = 0;
    while (!msg_valid && n < 30) begin @(negedge clk); n++; end
    c_kind = msg_valid ? msg_kind : 2'd0;
    c_addr = msg_addr;
    c_data = msg_data;
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag, input int n);
    logic seen = 1'b0;
    repeat (n) begin @(negedge clk); seen |= msg_valid; end
    check(tag, seen, 1'b0);
  endtask

  task automatic tbl_write(input int idx, input logic [AW-1:0] a,
                           input logic [31:0] d, input logic m);
    tbl_idx = 2'(idx); tbl_addr = a; tbl_data = d; tbl_mask = m; tbl_we = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", msg_valid, 1'b0);
    check("R1 intx", intx_out, 4'b0000);
    expect_none("R1 no pending", 4);

    // legacy mode, pin code 2
    leg_pin = 2'd2;
    irq_src[1] = 1'b1;
    get_msg();
    check("R3 assert kind", c_kind, 2'd1);
    check("R3 pin code", c_data[1:0], 2'd2);
    check("R2 intx level", intx_out, 4'b0100);
    irq_src[3] = 1'b1;
    expect_none("R3 level unchanged", 5);
    irq_src[1] = 1'b0;
    expect_none("R3 still high", 5);
    check("R2 still asserted", intx_out, 4'b0100);
    irq_src[3] = 1'b0;
    get_msg();
    check("R3 release kind", c_kind, 2'd2);
    check("R2 intx low", intx_out, 4'b0000);

    // R5: mode switch while asserted
    leg_pin = 2'd1;
    irq_src[0] = 1'b1;
    get_msg();
    check("R3 assert again", c_kind, 2'd1);
    msi_on = 1'b1; msi_addr = 64'hFEE0_0000; msi_data = 32'h100;
    get_msg();
    check("R5 release first", c_kind, 2'd2);
    check("R4 intx off", intx_out, 4'b0000);
    expect_none("R8 held source", 5);
    irq_src[0] = 1'b0;
    cyc(2);

    // R6: merge table
    for (int i = 0; i < 5; i++) begin
      msi_log2 = T_LG[i]; msi_data = T_BASE[i];
      irq_src[T_VEC[i]] = 1'b1;
      get_msg();
      check("R6 kind", c_kind, 2'd3);
      check("R6 addr", c_addr, 64'hFEE0_0000);
      check("R6 data", c_data, T_EXP[i]);
      irq_src = '0;
      cyc(2);
    end

    // R9 and R11
    msi_log2 = 3'd2; msi_data = 32'h200;
    irq_src = 4'b0110;
    cyc(4);
    check("R11 valid held", msg_valid, 1'b1);
    check("R11 data held", msg_data, 32'h201);
    get_msg();
    check("R9 lowest first", c_data, 32'h201);
    get_msg();
    check("R9 second", c_data, 32'h202);
    check("R4 no intx in msg mode", intx_out, 4'b0000);
    expect_none("R8 single message", 5);
    irq_src = '0;
    cyc(2);

    // R7 and R10, msi_on still 1 (table mode wins)
    msix_on = 1'b1;
    tbl_write(0, 64'hFEE0_1000, 32'h55, 1'b0);
    tbl_write(3, 64'hFEE0_3000, 32'h77, 1'b1);
    irq_src[3] = 1'b1;
    expect_none("R10 masked held", 6);
    irq_src[0] = 1'b1;
    get_msg();
    check("R7 addr", c_addr, 64'hFEE0_1000);
    check("R7 data", c_data, 32'h55);
    expect_none("R10 still masked", 4);
    tbl_write(3, 64'hFEE0_3000, 32'h77, 1'b0);
    get_msg();
    check("R10 unmask kind", c_kind, 2'd3);
    check("R10 unmask addr", c_addr, 64'hFEE0_3000);
    check("R10 unmask data", c_data, 32'h77);
    check("R4 intx off table mode", intx_out, 4'b0000);
    expect_none("R8 no repeat", 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule